// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control side of a two-input successive-approximation converter. Software reaches it through four byte-wide registers. A programmable prescaler derives a slower conversion tick from the system clock. Once enabled, the block waits a fixed settling interval measured in those ticks. Only then does it accept a start command, and the start bit stays set until the result has been captured.

Completion is reported by a sticky flag that can drive an interrupt line. The 10-bit result is split across two read-only registers. Software may also ask for the processor to be held frozen while a conversion runs; the freeze request is an output of the block, and everything else on the chip keeps running.

The analog converter itself is replaced by a behavioural model. At start it samples a digital level presented on one of two input ports, chosen by the channel bit. Clearing the enable bit at any time aborts a conversion in progress and re-arms the settling interval.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and `irq` and `cpu_freeze` are 0. The register addresses are: 0 control, 1 divider, 2 result high, 3 result low.
- R2: The divider register (bits 4:0, value D) makes the conversion tick period D+1 system clocks. A conversion lasts exactly 11·(D+1) clocks, counted from the clock edge that accepts the start write to the edge at which the start bit (control bit 2) reads 0.
- R3: The enable bit is control bit 0. After it is set, start writes are ignored for the next SETUP_TICKS·(D+1) clocks (default 4 ticks). A start write landing on the edge where that interval ends is still ignored; the next one is accepted.
- R4: While a conversion is busy, the start bit reads 1. A new start write, or a change of the channel bit, has no effect on the running conversion: its length and its result are unchanged.
- R5: The end-of-conversion flag is control bit 3. It becomes 1 on the same edge at which the start bit returns to 0. It stays 1 until software writes 0 to bit 3; writing 1 to bit 3 leaves it unchanged.
- R6: `irq` is 1 exactly when the end-of-conversion flag and the interrupt-enable bit (control bit 4) are both 1.
- R7: The channel bit is control bit 1, and the value written together with the start bit picks the input: 0 selects `ain0_level`, 1 selects `ain1_level`. At the end of the conversion, result bits 9:2 appear at address 2 and bits 1:0 at address 3 bits 1:0. Address 3 bits 7:2 read 0.
- R8: If the idle bit (control bit 5) is 1 in the write that starts a conversion, `cpu_freeze` is 1 from the next cycle until the conversion ends. If that bit is 0, `cpu_freeze` stays 0.
- R9: Writing 0 to the enable bit during a conversion clears the start bit and `cpu_freeze` at once, without setting the end-of-conversion flag. Re-enabling restarts the full settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ain0_level | input | 10 | Level the model converts on input 0 |
| ain1_level | input | 10 | Level the model converts on input 1 |
| irq | output | 1 | End-of-conversion interrupt request |
| cpu_freeze | output | 1 | Processor hold request during a conversion |

## Verification
On every cycle, the assertions check the following:
- A conversion never starts unless the settling interval is complete.
- Every normal end of a conversion sets the flag, and an abort never does.
- The flag only falls after a software clearing write.
- The freeze request never outlives the busy state.
- The result register moves only at the end of a conversion.

Only the directed scenarios can show the exact cycle counts for several divider values, the boundary edge of the settling interval, and the mapping of channel to result bits. They also cover the behaviour of writes that are ignored while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // register addresses
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_DIV  = 2'd1,
      REG_RESH = 2'd2,
      REG_RESL = 2'd3
   } adc_reg_e;

   // control register bit positions
   localparam int CTL_EN    = 0;
   localparam int CTL_CHAN  = 1;
   localparam int CTL_START = 2;
   localparam int CTL_EOC   = 3;
   localparam int CTL_IE    = 4;
   localparam int CTL_IDLE  = 5;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && !restart && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || restart || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_setup.sv
module adc_seq_setup #(
   parameter int SETUP_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   output logic rdy
);

   generate
      if (SETUP_TICKS == 0) begin : g_nowait
         logic rdy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdy_q <= 1'b0;
            else        rdy_q <= en;
         end
         assign rdy = rdy_q;
         logic unused_tick;
         assign unused_tick = tick;
      end else begin : g_count
         localparam int SW = $clog2(SETUP_TICKS + 1);
         logic [SW-1:0] cnt_q;
         logic          rdy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!en) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!rdy_q && tick) begin
               if (cnt_q == SW'(SETUP_TICKS - 1)) rdy_q <= 1'b1;
               else                               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign rdy = rdy_q;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv #(
   parameter int CONV_TICKS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic abort,
   input  logic tick,
   output logic busy,
   output logic done
);

   localparam int CW = $clog2(CONV_TICKS + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign busy = busy_q;
   assign done = busy_q && tick && !abort && (cnt_q == CW'(CONV_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_seq_stub.sv
module adc_seq_stub #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic             sel,
   input  logic [RES_W-1:0] lvl0,
   input  logic [RES_W-1:0] lvl1,
   output logic [RES_W-1:0] code
);

   logic [RES_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= '0;
      else if (sample) held_q <= sel ? lvl1 : lvl0;
   end

   assign code = held_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DIV_W       = 5,
   parameter int RES_W       = 10,
   parameter int SETUP_TICKS = 4,
   parameter int CONV_TICKS  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [RES_W-1:0] ain0_level,
   input  logic [RES_W-1:0] ain1_level,
   output logic             irq,
   output logic             cpu_freeze
);

   localparam int LO_W = RES_W - 8;

   generate
      if (DIV_W < 1 || DIV_W > 7) begin : g_bad_div
         $error("adc_seq_ctrl: DIV_W must be 1..7");
      end
      if (RES_W < 9 || RES_W > 15) begin : g_bad_res
         $error("adc_seq_ctrl: RES_W must be 9..15");
      end
      if (CONV_TICKS < 1) begin : g_bad_conv
         $error("adc_seq_ctrl: CONV_TICKS must be at least 1");
      end
   endgenerate

   logic             wr_ctrl, wr_div;
   logic             en_q, chan_q, eoc_q, ie_q, idle_q, freeze_q;
   logic [DIV_W-1:0] div_q;
   logic [RES_W-1:0] res_q;
   logic [RES_W-1:0] stub_code;
   logic             tick, rdy, busy, done, launch, abort;

   assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
   assign wr_div  = bus_wr && (bus_addr == REG_DIV);
   assign abort   = wr_ctrl && !bus_wdata[CTL_EN];
   assign launch  = wr_ctrl && bus_wdata[CTL_EN] && bus_wdata[CTL_START]
                    && en_q && rdy && !busy;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[7:6], bus_wdata[7:DIV_W]};

   adc_seq_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (launch),
      .div     (div_q),
      .tick    (tick)
   );

   adc_seq_setup #(.SETUP_TICKS(SETUP_TICKS)) u_setup (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .tick  (tick),
      .rdy   (rdy)
   );

   adc_seq_conv #(.CONV_TICKS(CONV_TICKS)) u_conv (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .abort  (abort),
      .tick   (tick),
      .busy   (busy),
      .done   (done)
   );

   adc_seq_stub #(.RES_W(RES_W)) u_stub (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (launch),
      .sel    (bus_wdata[CTL_CHAN]),
      .lvl0   (ain0_level),
      .lvl1   (ain1_level),
      .code   (stub_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         chan_q   <= 1'b0;
         eoc_q    <= 1'b0;
         ie_q     <= 1'b0;
         idle_q   <= 1'b0;
         freeze_q <= 1'b0;
         div_q    <= '0;
         res_q    <= '0;
      end else begin
         if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
         if (wr_ctrl) begin
            en_q   <= bus_wdata[CTL_EN];
            chan_q <= bus_wdata[CTL_CHAN];
            ie_q   <= bus_wdata[CTL_IE];
            idle_q <= bus_wdata[CTL_IDLE];
            if (!bus_wdata[CTL_EOC]) eoc_q <= 1'b0;
         end
         if (done) begin
            eoc_q <= 1'b1;
            res_q <= stub_code;
         end
         if (launch)             freeze_q <= bus_wdata[CTL_IDLE];
         else if (done || abort) freeze_q <= 1'b0;
      end
   end

   assign irq        = eoc_q && ie_q;
   assign cpu_freeze = freeze_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: bus_rdata = {2'b00, idle_q, ie_q, eoc_q, busy, chan_q, en_q};
         REG_DIV:  bus_rdata = {{(8-DIV_W){1'b0}}, div_q};
         REG_RESH: bus_rdata = res_q[RES_W-1 -: 8];
         REG_RESL: bus_rdata = {{(8-LO_W){1'b0}}, res_q[LO_W-1:0]};
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic             eoc_wbit,
   input logic             en,
   input logic             rdy,
   input logic             busy,
   input logic             eoc,
   input logic             freeze,
   input logic [RES_W-1:0] result
);

   // R3
   busy_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rdy));

   // R5
   end_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && en) |-> eoc);

   // R5
   flag_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> $fell(busy));

   // R5
   flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc) |-> $past(bus_wr && bus_addr == 2'd0 && !eoc_wbit));

   // R9
   abort_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !en) |-> !$rose(eoc));

   // R8
   freeze_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> busy);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(result));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .eoc_wbit (bus_wdata[3]),
   .en       (en_q),
   .rdy      (rdy),
   .busy     (busy),
   .eoc      (eoc_q),
   .freeze   (freeze_q),
   .result   (res_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

   localparam int SETUP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic [9:0] ain0_level = 10'h2A5;
   logic [9:0] ain1_level = 10'h13E;
   logic       irq, cpu_freeze;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ain0_level (ain0_level),
      .ain1_level (ain1_level),
      .irq        (irq),
      .cpu_freeze (cpu_freeze)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(input bit en, input bit ch, input bit st,
                                      input bit keep_eoc, input bit ie, input bit idle);
      return {2'b00, idle, ie, keep_eoc, st, ch, en};
   endfunction

   // called at a negedge; the write lands on the next posedge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_done(input int start_cyc, output int cyc);
      logic [7:0] c;
      cyc = start_cyc;
      rd(2'd0, c);
      while (c[2] && cyc < 2000) begin
         check("R5", "flag low while busy", int'(c[3]), 0);
         @(negedge clk);
         cyc++;
         rd(2'd0, c);
      end
      check("R5", "flag set when start clears", int'(c[3]), 1);
   endtask

   task automatic bring_up(input int d);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'(d));
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0));
      repeat (SETUP * (d + 1)) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1", $sformatf("reg %0d after reset", a), int'(v), 0);
      end
      check("R1", "irq after reset", int'(irq), 0);
      check("R1", "freeze after reset", int'(cpu_freeze), 0);
   endtask

   task automatic t_conv(input int d, input bit ch, input int lvl);
      int cyc;
      logic [7:0] v;
      bring_up(d);
      wr(2'd0, ctl(1, ch, 1, 0, 0, 0));
      rd(2'd0, v);
      check("R4", "start reads 1 while busy", int'(v[2]), 1);
      wait_done(0, cyc);
      check("R2", $sformatf("conversion clocks div=%0d", d), cyc, 11 * (d + 1));
      rd(2'd2, v);
      check("R7", "result high", int'(v), lvl >> 2);
      rd(2'd3, v);
      check("R7", "result low", int'(v), lvl & 3);
   endtask

   task automatic t_setup_gate;
      logic [7:0] v;
      int cyc;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd1);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0));        // lands at edge 0
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));        // edge 1: too early
      rd(2'd0, v);
      check("R3", "start right after enable ignored", int'(v[2]), 0);
      repeat (SETUP * 2 - 2) @(negedge clk);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));        // edge 8: interval boundary
      rd(2'd0, v);
      check("R3", "start on boundary edge ignored", int'(v[2]), 0);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));        // edge 9: accepted
      rd(2'd0, v);
      check("R3", "start after interval accepted", int'(v[2]), 1);
      wait_done(0, cyc);
      check("R2", "conversion clocks div=1", cyc, 22);
   endtask

   task automatic t_busy_ignore;
      int cyc;
      logic [7:0] v;
      bring_up(1);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
      repeat (4) @(negedge clk);
      wr(2'd0, ctl(1, 1, 1, 1, 0, 0));
      wait_done(5, cyc);
      check("R4", "length unchanged by busy write", cyc, 22);
      rd(2'd2, v);
      check("R4", "result still from input 0", int'(v), 10'h2A5 >> 2);
   endtask

   task automatic t_eoc_sticky;
      logic [7:0] v;
      repeat (10) @(negedge clk);
      rd(2'd0, v);
      check("R5", "flag held", int'(v[3]), 1);
      wr(2'd0, ctl(1, 0, 0, 1, 0, 0));
      rd(2'd0, v);
      check("R5", "writing 1 keeps flag", int'(v[3]), 1);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0));
      rd(2'd0, v);
      check("R5", "writing 0 clears flag", int'(v[3]), 0);
   endtask

   task automatic t_irq;
      int cyc;
      bring_up(0);
      wr(2'd0, ctl(1, 0, 1, 0, 1, 0));
      check("R6", "irq low while busy", int'(irq), 0);
      wait_done(0, cyc);
      check("R6", "irq with flag and enable", int'(irq), 1);
      wr(2'd0, ctl(1, 0, 0, 1, 0, 0));
      check("R6", "irq low when enable cleared", int'(irq), 0);
      wr(2'd0, ctl(1, 0, 0, 1, 1, 0));
      check("R6", "irq back with enable set", int'(irq), 1);
      wr(2'd0, ctl(1, 0, 0, 0, 1, 0));
      check("R6", "irq low when flag cleared", int'(irq), 0);
   endtask

   task automatic t_freeze;
      int cyc;
      bring_up(0);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 1));
      check("R8", "freeze during idle conversion", int'(cpu_freeze), 1);
      wait_done(0, cyc);
      check("R8", "freeze dropped at end", int'(cpu_freeze), 0);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
      check("R8", "no freeze without idle bit", int'(cpu_freeze), 0);
      wait_done(0, cyc);
   endtask

   task automatic t_abort;
      logic [7:0] v;
      int cyc;
      bring_up(0);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 1));
      repeat (3) @(negedge clk);
      wr(2'd0, ctl(0, 0, 0, 1, 0, 0));
      rd(2'd0, v);
      check("R9", "start cleared by abort", int'(v[2]), 0);
      check("R9", "no flag on abort", int'(v[3]), 0);
      check("R9", "freeze cleared by abort", int'(cpu_freeze), 0);
      repeat (15) @(negedge clk);
      rd(2'd0, v);
      check("R9", "flag stays low after abort", int'(v[3]), 0);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0));
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
      rd(2'd0, v);
      check("R9", "settling restarted after re-enable", int'(v[2]), 0);
      repeat (SETUP) @(negedge clk);
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0));
      rd(2'd0, v);
      check("R9", "start accepted after new interval", int'(v[2]), 1);
      wait_done(0, cyc);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup_gate();
      t_conv(0, 1'b0, 10'h2A5);
      t_conv(3, 1'b1, 10'h13E);
      t_busy_ignore();
      t_eoc_sticky();
      t_irq();
      t_freeze();
      t_abort();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule